// File: doc/BRIEF.md
# Activation Frame Allocation Controller

This block sits inside one dataflow processing element and owns its small pool of physical operand frames. Activations carry a 3-bit ID, so eight IDs exist, but only four physical frames of 64 sixteen-bit slots each are available. Before a function body runs, the element receives a stream of two-flit tokens on its input bus:

- A frame-control token binds an activation ID to a free physical frame, or releases that binding.
- A PE-local write token loads a word into instruction memory or into a slot of a bound frame.

The block keeps the ID-to-frame map and a valid bit for each frame. It turns accepted writes into single-cycle strobes toward instruction memory and frame storage. It raises one-cycle error pulses when the pool is exhausted, when an ID is bound twice, or when a token names an ID that has no frame. A side-band input lets a frame-release instruction executing inside the element free a frame without a token. A lookup port gives the matching logic the current binding for any ID.

Top module: `frame_alloc_ctrl`

## Requirements
- R1: After reset every frame is free, no activation ID is bound, `in_ready` is 1, and every strobe and error output is 0.
- R2: A token is two accepted beats on `in_flit`: the header, then the data word. A header with bits [15:13]=011, [12:11] equal to `PE_ID` and [10:9]=00 is frame control, with bit 8 as the operation (0 allocate, 1 release) and bits [2:0] as the activation ID. An allocate of an unbound ID binds it to the lowest-numbered free frame and sets that frame's valid bit. The new binding shows on the lookup port and on `frame_valid` in the cycle after the second beat is accepted.
- R3: An allocate while all frames are valid pulses `err_full` for one cycle and changes no binding and no valid bit.
- R4: An allocate of an ID that is already bound pulses `err_dup` for one cycle and leaves the existing binding unchanged.
- R5: A release token for a bound ID clears that frame's valid bit and the binding. A later allocate can reuse the freed frame, taking it when it is the lowest free one.
- R6: While `rel_valid` is 1, the ID on `rel_act` is released the same way. `in_ready` is 0 in that cycle, so no token beat is accepted at the same time.
- R7: A header with [10:9]=01 and bit 8 = 0 is an instruction-memory write. The cycle after the data beat, `imem_we` pulses with `imem_addr` set to bits [7:3] and `imem_wdata` set to the data word. The activation ID in bits [2:0] is ignored, even if it is unbound.
- R8: A header with [10:9]=01 and bit 8 = 1 is a frame-slot write to a bound ID. The cycle after the data beat, `fr_we` pulses with `fr_frame` set to the bound frame, `fr_slot` set to {0, bits [7:3]}, and `fr_wdata` set to the data word. Only slots 0 to 31 can be reached this way.
- R9: A release token, a side-band release, or a frame-slot write for an unbound ID pulses `err_unmapped` for one cycle. No write strobe is issued and no state changes.
- R10: A token whose header has a PE field other than `PE_ID`, or a prefix other than 011, is consumed with no strobe, no error and no state change.
- R11: Beat pairing stays aligned across ignored and erroring tokens. The beat that follows any completed token is always taken as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be accepted |
| in_flit | input | 16 | Input beat: header, then data word |
| rel_valid | input | 1 | Side-band frame release request |
| rel_act | input | 3 | Activation ID to release |
| lk_act | input | 3 | Activation ID to look up |
| lk_hit | output | 1 | Looked-up ID is bound |
| lk_frame | output | FR_W | Frame bound to the looked-up ID |
| frame_valid | output | N_FRAMES | Valid bit of each physical frame |
| imem_we | output | 1 | Instruction-memory write strobe |
| imem_addr | output | 5 | Instruction-memory write address |
| imem_wdata | output | 16 | Instruction-memory write data |
| fr_we | output | 1 | Frame-slot write strobe |
| fr_frame | output | FR_W | Physical frame being written |
| fr_slot | output | 6 | Slot within the frame |
| fr_wdata | output | 16 | Frame-slot write data |
| err_full | output | 1 | Allocate refused: no free frame |
| err_dup | output | 1 | Allocate refused: ID already bound |
| err_unmapped | output | 1 | Release or slot write for an unbound ID |

## Verification
Every strobe, error pulse and binding change is registered at the clock edge that accepts a token's second beat, or the edge that samples `rel_valid`. Each of these results is therefore due exactly one edge after that stimulus. The driver pushes the expected strobe or error record into a queue before it presents the beat. The monitor samples at the following falling edge, pops the record and compares it. Any output event that arrives with no record queued counts as a mismatch. The lookup port and `frame_valid` are combinational from the registered state. They are read at a falling edge after the token completes, which also shows that an ignored or refused token left the bindings as they were.

// File: rtl/frame_alloc_ctrl.sv
module frame_alloc_ctrl #(
  parameter int PE_ID    = 0,
  parameter int N_FRAMES = 4,
  localparam int FR_W    = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
  localparam int N_ACT   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [15:0]         in_flit,
  input  logic                rel_valid,
  input  logic [2:0]          rel_act,
  input  logic [2:0]          lk_act,
  output logic                lk_hit,
  output logic [FR_W-1:0]     lk_frame,
  output logic [N_FRAMES-1:0] frame_valid,
  output logic                imem_we,
  output logic [4:0]          imem_addr,
  output logic [15:0]         imem_wdata,
  output logic                fr_we,
  output logic [FR_W-1:0]     fr_frame,
  output logic [5:0]          fr_slot,
  output logic [15:0]         fr_wdata,
  output logic                err_full,
  output logic                err_dup,
  output logic                err_unmapped
);

  logic              phase;
  logic [15:0]       hdr;
  logic [N_ACT-1:0]  map_v;
  logic [FR_W-1:0]   map_f [N_ACT];
  logic              free_any;
  logic [FR_W-1:0]   free_idx;

  wire       acc       = in_valid && in_ready;
  wire       tok_done  = acc && phase;
  wire       hdr_local = (hdr[15:13] == 3'b011) && (hdr[12:11] == PE_ID[1:0]);
  wire       is_ctl    = hdr[10:9] == 2'b00;
  wire       is_wr     = hdr[10:9] == 2'b01;
  wire       t_bit     = hdr[8];
  wire [4:0] t_slot    = hdr[7:3];
  wire [2:0] t_act     = hdr[2:0];

  assign in_ready = !rel_valid;
  assign lk_hit   = map_v[lk_act];
  assign lk_frame = map_f[lk_act];

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N_FRAMES - 1; i >= 0; i--) begin
      if (!frame_valid[i]) begin
        free_any = 1'b1;
        free_idx = FR_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= 1'b0;
      hdr          <= '0;
      map_v        <= '0;
      frame_valid  <= '0;
      for (int a = 0; a < N_ACT; a++) map_f[a] <= '0;
      imem_we      <= 1'b0;
      imem_addr    <= '0;
      imem_wdata   <= '0;
      fr_we        <= 1'b0;
      fr_frame     <= '0;
      fr_slot      <= '0;
      fr_wdata     <= '0;
      err_full     <= 1'b0;
      err_dup      <= 1'b0;
      err_unmapped <= 1'b0;
    end else begin
      imem_we      <= 1'b0;
      fr_we        <= 1'b0;
      err_full     <= 1'b0;
      err_dup      <= 1'b0;
      err_unmapped <= 1'b0;
      if (acc) begin
        phase <= !phase;
        if (!phase) hdr <= in_flit;
      end
      if (rel_valid) begin
        if (map_v[rel_act]) begin
          map_v[rel_act]              <= 1'b0;
          frame_valid[map_f[rel_act]] <= 1'b0;
        end else begin
          err_unmapped <= 1'b1;
        end
      end else if (tok_done && hdr_local) begin
        if (is_ctl && !t_bit) begin
          if (map_v[t_act]) begin
            err_dup <= 1'b1;
          end else if (!free_any) begin
            err_full <= 1'b1;
          end else begin
            map_v[t_act]          <= 1'b1;
            map_f[t_act]          <= free_idx;
            frame_valid[free_idx] <= 1'b1;
          end
        end else if (is_ctl && t_bit) begin
          if (map_v[t_act]) begin
            map_v[t_act]              <= 1'b0;
            frame_valid[map_f[t_act]] <= 1'b0;
          end else begin
            err_unmapped <= 1'b1;
          end
        end else if (is_wr && !t_bit) begin
          imem_we    <= 1'b1;
          imem_addr  <= t_slot;
          imem_wdata <= in_flit;
        end else if (is_wr && t_bit) begin
          if (map_v[t_act]) begin
            fr_we    <= 1'b1;
            fr_frame <= map_f[t_act];
            fr_slot  <= {1'b0, t_slot};
            fr_wdata <= in_flit;
          end else begin
            err_unmapped <= 1'b1;
          end
        end
      end
    end
  end

  AST_FULL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_full |-> (frame_valid == $past(frame_valid)) && (map_v == $past(map_v))); // R3

  AST_DUP_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup |-> (map_v == $past(map_v)) && (frame_valid == $past(frame_valid))); // R4

  AST_WRITE_HITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fr_we |-> frame_valid[fr_frame]); // R8

  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_unmapped |-> !fr_we && !imem_we); // R9

  AST_MAP_MATCHES_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(frame_valid) == $countones(map_v)); // R5

  AST_ONE_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(frame_valid) <= $countones($past(frame_valid)) + 1); // R2

endmodule

// File: tb/tb_frame_alloc_ctrl.sv
module tb_frame_alloc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_flit;
  logic        rel_valid;
  logic [2:0]  rel_act;
  logic [2:0]  lk_act;
  logic        lk_hit;
  logic [1:0]  lk_frame;
  logic [3:0]  frame_valid;
  logic        imem_we;
  logic [4:0]  imem_addr;
  logic [15:0] imem_wdata;
  logic        fr_we;
  logic [1:0]  fr_frame;
  logic [5:0]  fr_slot;
  logic [15:0] fr_wdata;
  logic        err_full, err_dup, err_unmapped;

  frame_alloc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .rel_valid(rel_valid), .rel_act(rel_act),
    .lk_act(lk_act), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .frame_valid(frame_valid), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .fr_we(fr_we), .fr_frame(fr_frame),
    .fr_slot(fr_slot), .fr_wdata(fr_wdata), .err_full(err_full),
    .err_dup(err_dup), .err_unmapped(err_unmapped));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [28:0] exp_q [$];
  string       req_q [$];

  logic [7:0] m_v;
  logic [1:0] m_f [8];
  logic [3:0] m_fv;

  function automatic logic [15:0] ctl(input logic [1:0] pe, input logic op, input logic [2:0] act);
    return {3'b011, pe, 2'b00, op, 5'b0, act};
  endfunction

  function automatic logic [15:0] wr(input logic [1:0] pe, input logic rg, input logic [4:0] slot, input logic [2:0] act);
    return {3'b011, pe, 2'b01, rg, slot, act};
  endfunction

  function automatic logic [28:0] ev(input logic f, d, u, iw, fw, input logic [5:0] a, input logic [1:0] fr, input logic [15:0] dt);
    return {f, d, u, iw, fw, a, fr, dt};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [28:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic beat(input logic [15:0] f);
    @(negedge clk);
    in_valid = 1'b1;
    in_flit  = f;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic token(input logic [15:0] h, input logic [15:0] d, input string req);
    logic [2:0] a;
    int lo;
    a = h[2:0];
    if (h[15:13] == 3'b011 && h[12:11] == 2'd0) begin
      if (h[10:9] == 2'b00 && !h[8]) begin
        if (m_v[a]) expect_ev(ev(0,1,0,0,0,0,0,0), req);
        else if (m_fv == 4'hF) expect_ev(ev(1,0,0,0,0,0,0,0), req);
        else begin
          lo = 0;
          for (int i = 3; i >= 0; i--) if (!m_fv[i]) lo = i;
          m_v[a] = 1'b1; m_f[a] = 2'(lo); m_fv[lo] = 1'b1;
        end
      end else if (h[10:9] == 2'b00) begin
        if (m_v[a]) begin m_v[a] = 1'b0; m_fv[m_f[a]] = 1'b0; end
        else expect_ev(ev(0,0,1,0,0,0,0,0), req);
      end else if (h[10:9] == 2'b01 && !h[8]) begin
        expect_ev(ev(0,0,0,1,0,{1'b0,h[7:3]},0,d), req);
      end else if (h[10:9] == 2'b01) begin
        if (m_v[a]) expect_ev(ev(0,0,0,0,1,{1'b0,h[7:3]},m_f[a],d), req);
        else expect_ev(ev(0,0,1,0,0,0,0,0), req);
      end
    end
    beat(h);
    beat(d);
  endtask

  task automatic release_id(input logic [2:0] a, input string req);
    if (m_v[a]) begin m_v[a] = 1'b0; m_fv[m_f[a]] = 1'b0; end
    else expect_ev(ev(0,0,1,0,0,0,0,0), req);
    @(negedge clk);
    rel_valid = 1'b1;
    rel_act   = a;
    #1 check({req, " ready low during release"}, 32'(in_ready), 32'd0);
    @(posedge clk);
    #1 rel_valid = 1'b0;
  endtask

  task automatic look(input logic [2:0] a, input string req);
    @(negedge clk);
    lk_act = a;
    #1;
    check({req, " lookup hit"}, 32'(lk_hit), 32'(m_v[a]));
    if (m_v[a]) check({req, " lookup frame"}, 32'(lk_frame), 32'(m_f[a]));
    check({req, " frame_valid"}, 32'(frame_valid), 32'(m_fv));
  endtask

  initial begin : monitor
    logic [28:0] act_ev;
    forever begin
      @(negedge clk);
      if (rst_n && (imem_we || fr_we || err_full || err_dup || err_unmapped)) begin
        act_ev = {err_full, err_dup, err_unmapped, imem_we, fr_we,
                  imem_we ? {1'b0, imem_addr} : (fr_we ? fr_slot : 6'd0),
                  fr_we ? fr_frame : 2'd0,
                  imem_we ? imem_wdata : (fr_we ? fr_wdata : 16'd0)};
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL unexpected event: actual %h expected none", act_ev);
        end else begin
          check(req_q.pop_front(), 32'(act_ev), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    m_v = '0; m_fv = '0;
    for (int i = 0; i < 8; i++) m_f[i] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_flit = '0;
    rel_valid = 1'b0; rel_act = '0; lk_act = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset frame_valid", 32'(frame_valid), 32'd0);
    check("R1 reset ready", 32'(in_ready), 32'd1);
    check("R1 reset strobes", 32'({imem_we, fr_we, err_full, err_dup, err_unmapped}), 32'd0);
    look(3'd0, "R1");

    token(ctl(2'd0, 1'b0, 3'd5), 16'h0, "R2");   // R2 act5 -> frame0
    look(3'd5, "R2");
    token(ctl(2'd0, 1'b0, 3'd2), 16'h0, "R2");
    token(ctl(2'd0, 1'b0, 3'd7), 16'h0, "R2");
    token(ctl(2'd0, 1'b0, 3'd0), 16'h0, "R2");
    look(3'd7, "R2");
    token(ctl(2'd0, 1'b0, 3'd3), 16'h0, "R3");   // R3 pool exhausted
    look(3'd3, "R3");
    token(ctl(2'd0, 1'b0, 3'd2), 16'h0, "R4");   // R4 duplicate
    look(3'd2, "R4");
    token(wr(2'd0, 1'b1, 5'd31, 3'd7), 16'hA5A5, "R8");
    token(wr(2'd0, 1'b1, 5'd0, 3'd5), 16'h0F0F, "R8");
    token(wr(2'd0, 1'b0, 5'd9, 3'd4), 16'h1234, "R7"); // R7 act ignored
    token(ctl(2'd0, 1'b1, 3'd2), 16'h0, "R5");   // R5 release frame1
    look(3'd2, "R5");
    token(wr(2'd0, 1'b1, 5'd3, 3'd2), 16'hBEEF, "R9");
    token(ctl(2'd0, 1'b1, 3'd6), 16'h0, "R9");
    token(ctl(2'd0, 1'b0, 3'd3), 16'h0, "R5");   // R5 reuses frame1
    look(3'd3, "R5");
    release_id(3'd5, "R6");
    look(3'd5, "R6");
    release_id(3'd1, "R9");
    token(ctl(2'd1, 1'b0, 3'd1), 16'h0, "R10");  // R10 other PE
    token({3'b001, 13'h0001}, 16'h0, "R10");
    token(wr(2'd2, 1'b0, 5'd4, 3'd0), 16'h7777, "R10");
    look(3'd1, "R10");
    token(ctl(2'd0, 1'b0, 3'd1), 16'h0, "R11");  // R11 still aligned
    look(3'd1, "R11");
    token(wr(2'd0, 1'b1, 5'd17, 3'd1), 16'hC3C3, "R11");
    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule